// File: doc/BRIEF.md
# CCM Decrypt-and-Verify Sequencer

This block runs CCM-mode decryption with tag checking over 128-bit blocks. It does not contain a cipher. It drives an external 128-bit block-cipher engine through a request/response port. Each request names the chain it belongs to: IV, counter or MAC. The block keeps its own session context: the running MAC, the received MIC, the IV, the counter and a counter-modulus exponent. Software loads these slots while the block is idle.

After `start`, the sequencer does four things in order:
- It encrypts the IV to seed the MAC chain.
- It encrypts the initial counter and uses the result to unmask the received MIC in place.
- It folds one header block into the chain.
- It takes ciphertext blocks one at a time. For each block it advances the counter, encrypts it into keystream and outputs the plaintext. In the same cycle it issues the MAC-chain update for that plaintext.

The last block may be short. Its keystream tail is discarded and the plaintext is zero-padded before it enters the chain. At the end the final MAC sits in the MAC slot. A one-cycle `done` pulse carries `auth_ok`, which reports whether the upper 64 bits of the MAC match the unmasked MIC.

Top module: `ccm_dec_seq`

## Requirements
- R1: After synchronous reset the block is idle with `busy`, `done`, `out_valid`, `cq_valid` and `in_ready` low, `tag_out` zero, the IV, MIC and counter slots zero, and the exponent at 128.
- R2: `ld_valid` writes a slot only while idle. The selector values are 0 = IV, 1 = MIC (bits 127:64 kept, bits 63:0 forced to zero), 2 = counter, 3 = exponent (`ld_data[7:0]`). A load while busy is ignored.
- R3: A cipher request holds `cq_valid`, `cq_data` and `cq_tag` steady until `cq_ready`. The tags are 0 = IV, 1 = counter, 2 = MAC chain. The request order is IV, counter, MAC (header), then counter and MAC for each data block.
- R4: The MAC chain starts as E(IV). The MIC slot becomes E(counter0) XOR MIC. The header then gives MAC = E(MAC XOR header).
- R5: For each data block the counter is advanced before it is encrypted, and plaintext = E(counter) XOR ciphertext. Exactly one output is produced per input block.
- R6: A plaintext output pulse is raised in the same cycle as the MAC-chain request (tag 2) carrying MAC XOR plaintext.
- R7: With effective exponent e, a counter advance adds one modulo 2^e to bits below e and leaves the bits at or above e unchanged. An exponent above 128 acts as 128. An exponent of 0 freezes the counter.
- R8: The last block's `in_bytes` (1..16; 0 or above 16 acts as 16) keeps that many leading bytes, where byte 0 is bits 127:120. The other bytes are zero both in the output and in the MAC input. `out_bytes` gives the count, which is 16 for blocks that are not last. `out_last` marks the last block.
- R9: After completion, `tag_out` holds the final 128-bit MAC.
- R10: `done` is a one-cycle pulse after the last MAC update. `auth_ok` is high only with `done`, and only if MAC[127:64] equals the unmasked MIC[127:64].
- R11: `start` while busy, including the `done` cycle, is ignored.
- R12: `in_ready` is high only while the block waits for a ciphertext block, and one block is taken per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Context slot write strobe |
| ld_sel | input | 2 | Slot selector |
| ld_data | input | 128 | Slot write data |
| start | input | 1 | Begin an operation |
| hdr_data | input | 128 | Header block, sampled with start |
| in_valid | input | 1 | Ciphertext block valid |
| in_ready | output | 1 | Ready for a ciphertext block |
| in_data | input | 128 | Ciphertext block |
| in_last | input | 1 | Final block marker |
| in_bytes | input | 5 | Byte count of the final block |
| out_valid | output | 1 | Plaintext pulse |
| out_data | output | 128 | Plaintext block, zero-padded |
| out_bytes | output | 5 | Valid bytes in out_data |
| out_last | output | 1 | Final plaintext block |
| cq_valid | output | 1 | Cipher request valid |
| cq_ready | input | 1 | Cipher request accepted |
| cq_data | output | 128 | Block to encrypt |
| cq_tag | output | 2 | Chain the request belongs to |
| cr_valid | input | 1 | Cipher response valid |
| cr_data | input | 128 | Encrypted block |
| cr_tag | input | 2 | Tag echoed from the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| auth_ok | output | 1 | Tag comparison matched, with done |
| tag_out | output | 128 | MAC slot contents |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the plaintext output pulse and the MAC-chain request that consumes that plaintext. The bench's cipher stand-in stalls `cq_ready` on a fixed rhythm. This keeps the MAC request waiting while the output pulse is sampled, and every pulse is judged by whether a tag-2 request is visible at that moment.

The second pair is the `done` cycle and a new `start`. Every message ends with `start` driven exactly in the `done` cycle. The bench then confirms the block goes idle and issues no cipher requests beyond the 3 + 2·N expected for the message.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;
  localparam int BW      = 128;
  localparam int NBYTES  = BW / 8;
  localparam int EXP_W   = 8;
  localparam int CNT_W   = 5;

  localparam logic [1:0] OP_IV  = 2'd0;
  localparam logic [1:0] OP_CTR = 2'd1;
  localparam logic [1:0] OP_MAC = 2'd2;

  localparam logic [1:0] SEL_IV  = 2'd0;
  localparam logic [1:0] SEL_MIC = 2'd1;
  localparam logic [1:0] SEL_CTR = 2'd2;
  localparam logic [1:0] SEL_EXP = 2'd3;

  // add one modulo 2^e, leaving bits at or above e as they were
  function automatic logic [BW-1:0] ctr_next(input logic [BW-1:0] c,
                                             input logic [EXP_W-1:0] e);
    logic [BW-1:0] low_mask;
    logic [BW-1:0] sum;
    if (e >= EXP_W'(BW)) low_mask = '1;
    else                 low_mask = (BW'(1) << e) - BW'(1);
    sum = c + BW'(1);
    return (c & ~low_mask) | (sum & low_mask);
  endfunction

  // 0 or out-of-range counts mean a full block
  function automatic logic [CNT_W-1:0] bytes_norm(input logic [CNT_W-1:0] n);
    if (n == '0 || n > CNT_W'(NBYTES)) return CNT_W'(NBYTES);
    return n;
  endfunction

  // keep the leading n bytes (byte 0 at the top), zero the rest
  function automatic logic [BW-1:0] byte_keep(input logic [CNT_W-1:0] n);
    logic [BW-1:0] ones;
    ones = '1;
    return ones << (8 * (NBYTES - int'(bytes_norm(n))));
  endfunction
endpackage

// File: rtl/ccm_ctx.sv
`timescale 1ns/1ps
module ccm_ctx
  import ccm_pkg::*;
#(
  parameter int MIC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [1:0]       ld_sel,
  input  logic [BW-1:0]    ld_data,
  input  logic             mac_we,
  input  logic [BW-1:0]    mac_wd,
  input  logic             mic_we,
  input  logic [BW-1:0]    mic_wd,
  input  logic             ctr_step,
  output logic [BW-1:0]    iv_q,
  output logic [BW-1:0]    mic_q,
  output logic [BW-1:0]    ctr_q,
  output logic [EXP_W-1:0] exp_q,
  output logic [BW-1:0]    mac_q
);
  localparam int PAD_W = BW - MIC_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_q  <= '0;
      mic_q <= '0;
      ctr_q <= '0;
      mac_q <= '0;
      exp_q <= EXP_W'(BW);
    end else begin
      if (ld_en) begin
        case (ld_sel)
          SEL_IV:  iv_q  <= ld_data;
          SEL_MIC: mic_q <= {ld_data[BW-1 -: MIC_W], {PAD_W{1'b0}}};
          SEL_CTR: ctr_q <= ld_data;
          default: exp_q <= ld_data[EXP_W-1:0];
        endcase
      end
      if (mic_we)   mic_q <= mic_wd;
      if (ctr_step) ctr_q <= ctr_next(ctr_q, exp_q);
      if (mac_we)   mac_q <= mac_wd;
    end
  end
endmodule

// File: rtl/ccm_ctl.sv
`timescale 1ns/1ps
module ccm_ctl
  import ccm_pkg::*;
#(
  parameter int MIC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BW-1:0]    hdr,
  input  logic             in_valid,
  input  logic [BW-1:0]    in_data,
  input  logic             in_last,
  input  logic [CNT_W-1:0] in_bytes,
  output logic             in_ready,
  output logic             out_valid,
  output logic [BW-1:0]    out_data,
  output logic [CNT_W-1:0] out_bytes,
  output logic             out_last,
  output logic             cq_valid,
  input  logic             cq_ready,
  output logic [BW-1:0]    cq_data,
  output logic [1:0]       cq_tag,
  input  logic             cr_valid,
  input  logic [BW-1:0]    cr_data,
  input  logic [1:0]       cr_tag,
  input  logic [BW-1:0]    iv,
  input  logic [BW-1:0]    ctr,
  input  logic [BW-1:0]    mic,
  input  logic [BW-1:0]    mac,
  output logic             mac_we,
  output logic [BW-1:0]    mac_wd,
  output logic             mic_we,
  output logic [BW-1:0]    mic_wd,
  output logic             ctr_step,
  output logic             busy,
  output logic             done,
  output logic             auth_ok
);
  typedef enum logic [3:0] {
    S_IDLE, S_IV_Q, S_IV_W, S_C0_Q, S_C0_W, S_HD_Q, S_HD_W,
    S_BLK, S_KS_Q, S_KS_W, S_MC_Q, S_MC_W, S_FIN
  } st_t;

  st_t              st;
  logic [BW-1:0]    hdr_q, cblk_q, pt_q;
  logic [CNT_W-1:0] nb_q;
  logic             last_q, ov_q;

  logic hit_iv, hit_ctr, hit_mac;
  assign hit_iv  = cr_valid && (cr_tag == OP_IV);
  assign hit_ctr = cr_valid && (cr_tag == OP_CTR);
  assign hit_mac = cr_valid && (cr_tag == OP_MAC);

  assign busy     = (st != S_IDLE);
  assign in_ready = (st == S_BLK);
  assign done     = (st == S_FIN);
  assign auth_ok  = done && (mac[BW-1 -: MIC_W] == mic[BW-1 -: MIC_W]);
  assign ctr_step = in_ready && in_valid;

  assign mac_we = (st == S_IV_W && hit_iv) || (st == S_HD_W && hit_mac) ||
                  (st == S_MC_W && hit_mac);
  assign mac_wd = cr_data;
  assign mic_we = (st == S_C0_W) && hit_ctr;
  assign mic_wd = cr_data ^ mic;

  assign out_valid = ov_q;
  assign out_data  = pt_q;
  assign out_bytes = nb_q;
  assign out_last  = last_q;

  always_comb begin
    cq_valid = 1'b1;
    cq_data  = '0;
    cq_tag   = OP_IV;
    case (st)
      S_IV_Q: begin cq_data = iv;          cq_tag = OP_IV;  end
      S_C0_Q: begin cq_data = ctr;         cq_tag = OP_CTR; end
      S_HD_Q: begin cq_data = mac ^ hdr_q; cq_tag = OP_MAC; end
      S_KS_Q: begin cq_data = ctr;         cq_tag = OP_CTR; end
      S_MC_Q: begin cq_data = mac ^ pt_q;  cq_tag = OP_MAC; end
      default: cq_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      hdr_q  <= '0;
      cblk_q <= '0;
      pt_q   <= '0;
      nb_q   <= '0;
      last_q <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      ov_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin hdr_q <= hdr; st <= S_IV_Q; end
        S_IV_Q: if (cq_ready) st <= S_IV_W;
        S_IV_W: if (hit_iv)   st <= S_C0_Q;
        S_C0_Q: if (cq_ready) st <= S_C0_W;
        S_C0_W: if (hit_ctr)  st <= S_HD_Q;
        S_HD_Q: if (cq_ready) st <= S_HD_W;
        S_HD_W: if (hit_mac)  st <= S_BLK;
        S_BLK: if (in_valid) begin
          cblk_q <= in_data;
          last_q <= in_last;
          nb_q   <= in_last ? bytes_norm(in_bytes) : CNT_W'(NBYTES);
          st     <= S_KS_Q;
        end
        S_KS_Q: if (cq_ready) st <= S_KS_W;
        S_KS_W: if (hit_ctr) begin
          pt_q <= (cr_data ^ cblk_q) & byte_keep(nb_q);
          ov_q <= 1'b1;
          st   <= S_MC_Q;
        end
        S_MC_Q: if (cq_ready) st <= S_MC_W;
        S_MC_W: if (hit_mac) st <= last_q ? S_FIN : S_BLK;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccm_dec_seq.sv
`timescale 1ns/1ps
module ccm_dec_seq
  import ccm_pkg::*;
#(
  parameter int MIC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [1:0]       ld_sel,
  input  logic [BW-1:0]    ld_data,
  input  logic             start,
  input  logic [BW-1:0]    hdr_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BW-1:0]    in_data,
  input  logic             in_last,
  input  logic [CNT_W-1:0] in_bytes,
  output logic             out_valid,
  output logic [BW-1:0]    out_data,
  output logic [CNT_W-1:0] out_bytes,
  output logic             out_last,
  output logic             cq_valid,
  input  logic             cq_ready,
  output logic [BW-1:0]    cq_data,
  output logic [1:0]       cq_tag,
  input  logic             cr_valid,
  input  logic [BW-1:0]    cr_data,
  input  logic [1:0]       cr_tag,
  output logic             busy,
  output logic             done,
  output logic             auth_ok,
  output logic [BW-1:0]    tag_out
);
  // named internal events, observed by the bound checker
  logic             ev_ld_take;
  logic             ev_ctr_step;
  logic             ev_mic_recover;
  logic             ev_mac_update;
  logic [BW-1:0]    ctx_iv, ctx_mic, ctx_ctr, ctx_mac;
  logic [EXP_W-1:0] ctx_exp;
  logic [BW-1:0]    mac_wd, mic_wd;

  assign ev_ld_take = ld_valid && !busy;
  assign tag_out    = ctx_mac;

  ccm_ctx #(.MIC_W(MIC_W)) u_ctx (
    .clk(clk), .rst(rst),
    .ld_en(ev_ld_take), .ld_sel(ld_sel), .ld_data(ld_data),
    .mac_we(ev_mac_update), .mac_wd(mac_wd),
    .mic_we(ev_mic_recover), .mic_wd(mic_wd),
    .ctr_step(ev_ctr_step),
    .iv_q(ctx_iv), .mic_q(ctx_mic), .ctr_q(ctx_ctr), .exp_q(ctx_exp), .mac_q(ctx_mac)
  );

  ccm_ctl #(.MIC_W(MIC_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .hdr(hdr_data),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
    .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_bytes(out_bytes), .out_last(out_last),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_data(cq_data), .cq_tag(cq_tag),
    .cr_valid(cr_valid), .cr_data(cr_data), .cr_tag(cr_tag),
    .iv(ctx_iv), .ctr(ctx_ctr), .mic(ctx_mic), .mac(ctx_mac),
    .mac_we(ev_mac_update), .mac_wd(mac_wd),
    .mic_we(ev_mic_recover), .mic_wd(mic_wd),
    .ctr_step(ev_ctr_step),
    .busy(busy), .done(done), .auth_ok(auth_ok)
  );
endmodule

// File: rtl/ccm_dec_seq_chk.sv
`timescale 1ns/1ps
module ccm_dec_seq_chk
  import ccm_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             auth_ok,
  input logic             in_ready,
  input logic             out_valid,
  input logic             cq_valid,
  input logic             cq_ready,
  input logic [BW-1:0]    cq_data,
  input logic [1:0]       cq_tag,
  input logic             ld_valid,
  input logic [EXP_W-1:0] ctx_exp,
  input logic [BW-1:0]    ctx_ctr,
  input logic             ev_ctr_step,
  input logic             ev_mic_recover
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cq_valid && !cq_ready |=> cq_valid && $stable(cq_data) && $stable(cq_tag));

  // R6
  out_with_mac_req_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cq_valid && cq_tag == OP_MAC);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy && !done);

  // R10
  auth_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    auth_ok |-> done);

  // R2
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && ld_valid |=> $stable(ctx_exp));

  // R7
  ctr_moves_chk: assert property (@(posedge clk) disable iff (rst)
    ev_ctr_step && ctx_exp != '0 |=> ctx_ctr != $past(ctx_ctr));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cq_valid && !in_ready && !ev_mic_recover);

  // R12
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, out_valid, in_ready}));
endmodule

bind ccm_dec_seq ccm_dec_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .auth_ok(auth_ok),
  .in_ready(in_ready), .out_valid(out_valid),
  .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_data(cq_data), .cq_tag(cq_tag),
  .ld_valid(ld_valid), .ctx_exp(ctx_exp), .ctx_ctr(ctx_ctr),
  .ev_ctr_step(ev_ctr_step), .ev_mic_recover(ev_mic_recover)
);

// File: tb/ccm_dec_seq_test.sv
`timescale 1ns/1ps
module ccm_dec_seq_test;
  localparam logic [127:0] KEYMIX = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic         ld_valid = 1'b0;
  logic [1:0]   ld_sel = '0;
  logic [127:0] ld_data = '0;
  logic         start = 1'b0;
  logic [127:0] hdr_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_last = 1'b0;
  logic [4:0]   in_bytes = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic [4:0]   out_bytes;
  logic         out_last;
  logic         cq_valid;
  logic         cq_ready = 1'b0;
  logic [127:0] cq_data;
  logic [1:0]   cq_tag;
  logic         cr_valid = 1'b0;
  logic [127:0] cr_data = '0;
  logic [1:0]   cr_tag = '0;
  logic         busy, done, auth_ok;
  logic [127:0] tag_out;

  ccm_dec_seq uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data),
    .start(start), .hdr_data(hdr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_bytes(in_bytes),
    .out_valid(out_valid), .out_data(out_data), .out_bytes(out_bytes), .out_last(out_last),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_data(cq_data), .cq_tag(cq_tag),
    .cr_valid(cr_valid), .cr_data(cr_data), .cr_tag(cr_tag),
    .busy(busy), .done(done), .auth_ok(auth_ok), .tag_out(tag_out)
  );

  int checks = 0;
  int failures = 0;
  int hs_cnt = 0;
  int out_idx = 0;
  int exp_n = 0;
  logic [127:0] exp_pt [8];
  logic [4:0]   exp_nb [8];

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // stand-in cipher: rotate left by 13, then mix in a constant
  function automatic logic [127:0] enc(input logic [127:0] x);
    return {x[114:0], x[127:115]} ^ KEYMIX;
  endfunction

  // bitwise model of the modular increment
  function automatic logic [127:0] inc_m(input logic [127:0] c, input int e);
    logic [127:0] t;
    t = c + 128'd1;
    for (int i = 0; i < 128; i++) if (i >= e) t[i] = c[i];
    return t;
  endfunction

  function automatic logic [127:0] keep_m(input logic [127:0] x, input int n);
    logic [127:0] t;
    t = x;
    for (int i = 0; i < 16; i++) if (i >= n) t[127-8*i -: 8] = 8'h00;
    return t;
  endfunction

  function automatic logic [1:0] tag_at(input int j);
    if (j == 0) return 2'd0;
    if (j == 1) return 2'd1;
    if (j == 2) return 2'd2;
    return ((j - 3) % 2 == 0) ? 2'd1 : 2'd2;
  endfunction

  // cipher responder, driven between clock edges
  initial begin
    bit pend = 0;
    int dly = 0;
    int rr = 0;
    bit stall = 0;
    logic [127:0] pdata = '0, sdata = '0;
    logic [1:0]   ptag = '0, stag = '0;
    forever begin
      @(negedge clk);
      cr_valid = 1'b0;
      if (stall)   // R3
        chk(cq_valid && cq_data == sdata && cq_tag == stag, "R3 request held",
            {126'd0, cq_tag}, {126'd0, stag});
      if (pend) begin
        if (dly == 0) begin
          cr_valid = 1'b1; cr_data = enc(pdata); cr_tag = ptag; pend = 0;
        end else dly--;
      end
      rr++;
      cq_ready = (rr % 3) != 0;
      if (cq_valid && cq_ready) begin
        chk(cq_tag == tag_at(hs_cnt), "R3 request tag order",
            {126'd0, cq_tag}, {126'd0, tag_at(hs_cnt)});
        hs_cnt++;
        pend = 1; dly = rr % 2; pdata = cq_data; ptag = cq_tag;
      end
      stall = cq_valid && !cq_ready;
      sdata = cq_data; stag = cq_tag;
    end
  end

  // plaintext monitor
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (out_idx < exp_n) begin
          // R5 R8
          chk(out_data == exp_pt[out_idx], "R5 plaintext", out_data, exp_pt[out_idx]);
          chk(out_bytes == exp_nb[out_idx], "R8 byte count",
              {123'd0, out_bytes}, {123'd0, exp_nb[out_idx]});
          chk(out_last == (out_idx == exp_n - 1), "R8 last flag",
              {127'd0, out_last}, {127'd0, out_idx == exp_n - 1});
        end else chk(1'b0, "R5 extra output", 128'(out_idx), 128'(exp_n));
        // R6
        chk(cq_valid && cq_tag == 2'd2, "R6 MAC request with output",
            {126'd0, cq_tag}, 128'd2);
        out_idx++;
      end
    end
  end

  task automatic ld(input logic [1:0] s, input logic [127:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = s; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_msg(input int nblk, input int lastn, input bit good, input bit poke,
                         input bit load_iv, input logic [127:0] ivv,
                         input logic [127:0] c0, input int ex, input int seed);
    logic [127:0] m, k0, c, ks, pt, hdr;
    logic [127:0] blk [8];
    logic [63:0] mic_hi;
    int e, n;
    hdr = {ivv[63:0], c0[127:64]} ^ 128'(seed);
    for (int i = 0; i < nblk; i++)
      blk[i] = {32'(seed * 7 + i), 32'(seed * 5 + i * 11), 32'hA5A5_0000 ^ 32'(i),
                32'(seed) ^ 32'h1234_8765};
    e = (ex > 128) ? 128 : ex;
    m  = enc(ivv);
    k0 = enc(c0);
    m  = enc(m ^ hdr);
    c  = c0;
    for (int i = 0; i < nblk; i++) begin
      c  = inc_m(c, e);
      ks = enc(c);
      n  = (i == nblk - 1) ? ((lastn == 0) ? 16 : lastn) : 16;
      pt = keep_m(ks ^ blk[i], n);
      exp_pt[i] = pt;
      exp_nb[i] = 5'(n);
      m = enc(m ^ pt);
    end
    mic_hi = k0[127:64] ^ m[127:64] ^ (good ? 64'd0 : 64'h100);
    if (load_iv) ld(2'd0, ivv);
    ld(2'd1, {mic_hi, 64'hDEAD_BEEF_0BAD_F00D});
    ld(2'd2, c0);
    ld(2'd3, 128'(ex));
    exp_n = nblk; out_idx = 0; hs_cnt = 0;
    @(negedge clk);
    start = 1'b1; hdr_data = hdr;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nblk; i++) begin
      in_valid = 1'b1; in_data = blk[i]; in_last = (i == nblk - 1);
      in_bytes = (i == nblk - 1) ? 5'(lastn) : 5'd3;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (poke && i == 0) begin   // R2 R11: start and IV load while busy
        start = 1'b1; ld_valid = 1'b1; ld_sel = 2'd0; ld_data = ~ivv;
        @(negedge clk);
        start = 1'b0; ld_valid = 1'b0;
      end
    end
    while (!done) @(negedge clk);
    chk(auth_ok == good, "R10 auth flag", {127'd0, auth_ok}, {127'd0, good});
    chk(tag_out == m, "R9 final MAC", tag_out, m);
    start = 1'b1;   // R11: start in the done cycle
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy, "R11 idle after done", {127'd0, busy}, 128'd0);
    chk(hs_cnt == 3 + 2 * nblk, "R11 request count", 128'(hs_cnt), 128'(3 + 2 * nblk));
    chk(out_idx == nblk, "R5 output count", 128'(out_idx), 128'(nblk));
    chk(!in_ready, "R12 no ready when idle", {127'd0, in_ready}, 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 128'd0, 128'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done && !out_valid && !cq_valid && !in_ready, "R1 reset outputs",
        {123'd0, busy, done, out_valid, cq_valid, in_ready}, 128'd0);
    chk(tag_out == '0, "R1 MAC slot cleared", tag_out, 128'd0);

    // R4 full blocks, authentic and forged
    run_msg(3, 16, 1, 0, 1, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
            128'h0000_0000_0000_0000_0000_0000_0000_0100, 128, 1);
    run_msg(3, 16, 0, 0, 1, 128'h9999_2222_3333_4444_5555_6666_7777_0001,
            128'h0000_0000_0000_0000_0000_0000_0000_0200, 128, 2);
    // R8 sweep of the final byte count
    for (int nb = 1; nb <= 16; nb++)
      run_msg(2, nb, (nb % 3) != 0, 0, 1, 128'(nb) * 128'h0101_0203,
              128'hFFFF_0000_0000_0000_0000_0000_0000_0000 | 128'(nb), 128, 10 + nb);
    // R8 zero count acts as full block
    run_msg(2, 0, 1, 0, 1, 128'h55, 128'h77, 128, 40);
    // R7 wrap inside an 8-bit field with upper bits preserved
    run_msg(4, 16, 1, 0, 1, 128'hABCD, 128'hCAFE_0000_0000_0000_0000_0000_0000_12FD, 8, 50);
    // R7 exponent 0 freezes the counter
    run_msg(2, 16, 1, 0, 1, 128'h42, 128'h1234_5678, 0, 51);
    // R7 exponent above 128 wraps the full width
    run_msg(2, 9, 1, 0, 1, 128'h43, {128{1'b1}}, 200, 52);
    // R7 single-bit field
    run_msg(3, 16, 0, 0, 1, 128'h44, 128'hF0F1, 1, 53);
    // R2 R11 start and IV write while busy, then reuse the old IV
    run_msg(2, 16, 1, 1, 1, 128'hBEEF_0001, 128'h500, 128, 60);
    run_msg(2, 16, 1, 0, 0, 128'hBEEF_0001, 128'h600, 128, 61);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule